// File: doc/BRIEF.md
# NAND Factory Bad-Block Scanner

The scanner walks a NAND array once per start request and classifies every erase block as usable or bad from the marker byte the maker leaves in the spare area. For each block it requests two page reads through a small request port. Each request carries a page address and is answered by a stream of bytes qualified by a valid strobe. Only one byte of each page matters. The rest of the stream is counted and thrown away.

The verdicts go into an internal bitmap with one bit per block. After the scan finishes, a host reads the bitmap by block index. A bad-block total is presented together with the completion pulse. The flash bus protocol, error correction and rewriting of markers are handled elsewhere.

Top module: `nand_badblock_scan`

## Requirements
- R1: While and right after a synchronous reset, `busy`, `done` and `rd_req` are 0 and `bad_count` is 0.
- R2: A `start` pulse seen while idle makes `busy` read 1 on the following cycle, and `busy` stays 1 until the scan completes.
- R3: Blocks are visited in ascending order from 0 to NUM_BLOCKS-1. Block n issues a request for page address n<<5, then a request for (n<<5)+1. Each request is a one-cycle `rd_req` pulse. A new request is issued only after the previous page's last byte has been accepted.
- R4: The marker of a page is the byte at index 517 (0-based), counting only cycles with `rd_valid`=1. No other byte of the page influences the verdict.
- R5: A block is bad when either of its two marker bytes differs from 8'hFF. Otherwise it is good.
- R6: `done` pulses for exactly one cycle at the end of a scan. In that cycle `bad_count` equals the number of bad blocks found, and `busy` is 0.
- R7: With `busy`=0, a `map_rd_en` pulse returns the verdict of block `map_rd_idx` on `map_rd_bad` one cycle later (1 = bad, 0 = good).
- R8: A bitmap read requested while `busy`=1 is ignored, and `map_rd_bad` keeps its previous value.
- R9: A `start` pulse seen while a scan is running is ignored. The request sequence and the final count are unchanged.
- R10: A page ends after exactly 528 valid bytes. Cycles with `rd_valid`=0 are gaps that are not counted.
- R11: Every new scan restarts the count from zero and overwrites every bitmap bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a scan of all blocks |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle completion pulse |
| bad_count | output | $clog2(NUM_BLOCKS+1) | Number of bad blocks, valid at `done` |
| rd_req | output | 1 | One-cycle page read request |
| rd_addr | output | BLK_W+PAGE_SHIFT | Page address of the request |
| rd_valid | input | 1 | Page byte valid strobe |
| rd_byte | input | 8 | Page byte |
| map_rd_en | input | 1 | Bitmap read enable |
| map_rd_idx | input | BLK_W | Block index to read |
| map_rd_bad | output | 1 | Bad flag of the block read, one cycle later |

## Verification
Each request appears one cycle after the event that caused it. That event is either `start` or the page end, and the page end is itself registered one cycle after the last valid byte. The bench's page model therefore samples `rd_req` at falling edges and compares every address with the sequence it expects. `done` comes two cycles after the second marker page of the last block ends. The bench waits for it at falling edges, checks the count in that cycle and confirms the pulse has dropped one cycle later. A bitmap read is judged at the falling edge after the rising edge that took the enable. The blocked-read test compares that same sample with the value held before the read.

// File: rtl/nbs_pkg.sv
`timescale 1ns/1ps
package nbs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PAGE = 2'd1,
    ST_DONE = 2'd2
  } scan_st_t;

  localparam logic [7:0] ERASED_BYTE = 8'hFF;
endpackage

// File: rtl/bbs_marker_tap.sv
`timescale 1ns/1ps
module bbs_marker_tap #(
  parameter int PAGE_BYTES  = 528,
  parameter int MARK_OFFSET = 517
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       arm,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  output logic [7:0] mark_q,
  output logic       page_end
);
  localparam int IDX_W = (PAGE_BYTES > 1) ? $clog2(PAGE_BYTES) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAGE_BYTES - 1);
  localparam logic [IDX_W-1:0] MARK_IDX = IDX_W'(MARK_OFFSET);

  logic [IDX_W-1:0] idx;

  // counts only qualified beats; the marker is latched, everything else dropped
  always_ff @(posedge clk) begin
    if (rst) begin
      idx      <= '0;
      mark_q   <= nbs_pkg::ERASED_BYTE;
      page_end <= 1'b0;
    end else begin
      page_end <= 1'b0;
      if (!arm) begin
        idx <= '0;
      end else if (in_valid) begin
        if (idx == MARK_IDX) mark_q <= in_byte;
        if (idx == LAST_IDX) begin
          idx      <= '0;
          page_end <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  // R10: a page is longer than one beat, so end pulses never touch
  p_end_single_r10: assert property (@(posedge clk) disable iff (rst)
    page_end |=> !page_end);
  // R10: the counter never runs past the last byte of a page
  p_idx_range_r10: assert property (@(posedge clk) disable iff (rst)
    idx <= LAST_IDX);
endmodule

// File: rtl/bbs_bad_map.sv
`timescale 1ns/1ps
module bbs_bad_map #(
  parameter int NUM_BLOCKS = 64,
  parameter int BLK_W      = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [BLK_W-1:0] wr_idx,
  input  logic             wr_bad,
  input  logic             rd_en,
  input  logic [BLK_W-1:0] rd_idx,
  output logic             rd_bad
);
  logic mem [NUM_BLOCKS];

  // plain write port, no reset, so a RAM primitive can be inferred
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_bad;
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) rd_bad <= 1'b0;
    else if (rd_en) rd_bad <= mem[rd_idx];
  end

  // R7: without a read enable the output register holds
  p_read_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_bad));
endmodule

// File: rtl/bbs_scan_ctl.sv
`timescale 1ns/1ps
module bbs_scan_ctl
  import nbs_pkg::*;
#(
  parameter int NUM_BLOCKS = 64,
  parameter int BLK_W      = 6,
  parameter int PAGE_SHIFT = 5,
  parameter int CNT_W      = 7
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start,
  input  logic                        page_end,
  input  logic [7:0]                  mark_byte,
  output logic                        busy,
  output logic                        arm,
  output logic                        rd_req,
  output logic [BLK_W+PAGE_SHIFT-1:0] rd_addr,
  output logic                        wr_en,
  output logic [BLK_W-1:0]            wr_idx,
  output logic                        wr_bad,
  output logic                        done,
  output logic [CNT_W-1:0]            bad_count
);
  localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLOCKS - 1);

  scan_st_t         st;
  logic [BLK_W-1:0] blk;
  logic             second;
  logic             first_bad;
  logic             mark_bad;
  logic             blk_bad;

  assign mark_bad = (mark_byte != ERASED_BYTE);
  assign blk_bad  = first_bad | mark_bad;
  assign busy     = (st != ST_IDLE);
  assign arm      = (st == ST_PAGE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      blk       <= '0;
      second    <= 1'b0;
      first_bad <= 1'b0;
      rd_req    <= 1'b0;
      rd_addr   <= '0;
      wr_en     <= 1'b0;
      wr_idx    <= '0;
      wr_bad    <= 1'b0;
      done      <= 1'b0;
      bad_count <= '0;
    end else begin
      rd_req <= 1'b0;
      wr_en  <= 1'b0;
      done   <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            blk       <= '0;
            second    <= 1'b0;
            bad_count <= '0;
            rd_req    <= 1'b1;
            rd_addr   <= '0;
            st        <= ST_PAGE;
          end
        end
        ST_PAGE: begin
          if (page_end) begin
            if (!second) begin
              first_bad <= mark_bad;
              second    <= 1'b1;
              rd_req    <= 1'b1;
              rd_addr   <= {blk, PAGE_SHIFT'(1)};
            end else begin
              second    <= 1'b0;
              wr_en     <= 1'b1;
              wr_idx    <= blk;
              wr_bad    <= blk_bad;
              bad_count <= bad_count + CNT_W'(blk_bad);
              if (blk == LAST_BLK) begin
                st <= ST_DONE;
              end else begin
                blk     <= blk + 1'b1;
                rd_req  <= 1'b1;
                rd_addr <= {blk + 1'b1, PAGE_SHIFT'(0)};
              end
            end
          end
        end
        ST_DONE: begin
          done <= 1'b1;
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R3: each request lasts one cycle
  p_req_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req);
  // R3: requested page is always page 0 or 1 of a block
  p_req_page_r3: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> (rd_addr[PAGE_SHIFT-1:0] <= PAGE_SHIFT'(1)));
  // R3: no request while a page is still streaming without its end
  p_req_after_end_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_req && busy && $past(busy)) |-> $past(page_end));
  // R6: done is a single-cycle pulse seen with the scanner idle
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R6: the count cannot exceed the number of blocks
  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
    bad_count <= CNT_W'(NUM_BLOCKS));
endmodule

// File: rtl/nand_badblock_scan.sv
`timescale 1ns/1ps
module nand_badblock_scan #(
  parameter int NUM_BLOCKS  = 64,
  parameter int PAGE_BYTES  = 528,
  parameter int MARK_OFFSET = 517,
  parameter int PAGE_SHIFT  = 5,
  parameter int BLK_W       = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1,
  parameter int CNT_W       = $clog2(NUM_BLOCKS + 1),
  parameter int ADDR_W      = BLK_W + PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  bad_count,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [7:0]        rd_byte,
  input  logic              map_rd_en,
  input  logic [BLK_W-1:0]  map_rd_idx,
  output logic              map_rd_bad
);
  logic             arm;
  logic             page_end;
  logic [7:0]       mark_q;
  logic             wr_en;
  logic [BLK_W-1:0] wr_idx;
  logic             wr_bad;
  logic             map_take;

  assign map_take = map_rd_en & ~busy;

  bbs_marker_tap #(
    .PAGE_BYTES (PAGE_BYTES),
    .MARK_OFFSET(MARK_OFFSET)
  ) u_tap (
    .clk     (clk),
    .rst     (rst),
    .arm     (arm),
    .in_valid(rd_valid),
    .in_byte (rd_byte),
    .mark_q  (mark_q),
    .page_end(page_end)
  );

  bbs_scan_ctl #(
    .NUM_BLOCKS(NUM_BLOCKS),
    .BLK_W     (BLK_W),
    .PAGE_SHIFT(PAGE_SHIFT),
    .CNT_W     (CNT_W)
  ) u_ctl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .page_end (page_end),
    .mark_byte(mark_q),
    .busy     (busy),
    .arm      (arm),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_bad   (wr_bad),
    .done     (done),
    .bad_count(bad_count)
  );

  bbs_bad_map #(
    .NUM_BLOCKS(NUM_BLOCKS),
    .BLK_W     (BLK_W)
  ) u_map (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_en),
    .wr_idx(wr_idx),
    .wr_bad(wr_bad),
    .rd_en (map_take),
    .rd_idx(map_rd_idx),
    .rd_bad(map_rd_bad)
  );

  // R8: bitmap output frozen while a scan runs
  p_busy_read_hold_r8: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(map_rd_bad));
  // R9: a start during a scan never drops busy
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !done) |=> (busy || done));
  // R2: start from idle raises busy
  p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> busy);
endmodule

// File: tb/test_nand_badblock_scan.sv
`timescale 1ns/1ps
module test_nand_badblock_scan;
  localparam int NB = 16;
  localparam int PB = 528;
  localparam int MO = 517;
  localparam int PS = 5;
  localparam int BW = 4;
  localparam int CW = 5;
  localparam int AW = BW + PS;

  logic          clk = 1'b0;
  logic          rst;
  logic          start;
  logic          busy, done;
  logic [CW-1:0] bad_count;
  logic          rd_req;
  logic [AW-1:0] rd_addr;
  logic          rd_valid;
  logic [7:0]    rd_byte;
  logic          map_rd_en;
  logic [BW-1:0] map_rd_idx;
  logic          map_rd_bad;

  int n_chk = 0;
  int n_bad = 0;
  int req_n = 0;
  int gap_pct = 0;
  logic [7:0] marks [NB][2];

  always #4 clk = ~clk;

  nand_badblock_scan #(
    .NUM_BLOCKS (NB),
    .PAGE_BYTES (PB),
    .MARK_OFFSET(MO),
    .PAGE_SHIFT (PS)
  ) i_nand_badblock_scan (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .bad_count(bad_count), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_byte(rd_byte), .map_rd_en(map_rd_en),
    .map_rd_idx(map_rd_idx), .map_rd_bad(map_rd_bad)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic bit exp_blk_bad(input int b);
    return (marks[b][0] != 8'hFF) || (marks[b][1] != 8'hFF);
  endfunction

  function automatic int exp_total();
    int t = 0;
    for (int b = 0; b < NB; b++) t += exp_blk_bad(b);
    return t;
  endfunction

  // bytes beside the marker are never erased, other filler is random (R4)
  function automatic logic [7:0] filler(input int i);
    if (i == MO - 1 || i == MO + 1) return 8'h00;
    return 8'($urandom);
  endfunction

  // page source model
  initial begin
    rd_valid = 1'b0;
    rd_byte  = 8'h00;
    forever begin
      @(negedge clk);
      if (rd_req) begin
        int exp_a;
        int b, p, i;
        exp_a = ((req_n / 2) << PS) + (req_n % 2);
        chk(rd_addr == AW'(exp_a), "R3 address", rd_addr, exp_a);
        b = req_n / 2;
        p = req_n % 2;
        if (b >= NB) b = NB - 1;
        req_n++;
        i = 0;
        while (i < PB) begin
          if (int'($urandom % 100) < gap_pct) begin
            rd_valid = 1'b0;  // R10 gap cycle
          end else begin
            rd_valid = 1'b1;
            rd_byte  = (i == MO) ? marks[b][p] : filler(i);
            i++;
          end
          @(negedge clk);
          if (rd_req) chk(1'b0, "R3 overlap", 1, 0);
        end
        rd_valid = 1'b0;
      end
    end
  end

  task automatic read_map(input int idx, output logic v);
    map_rd_en  = 1'b1;
    map_rd_idx = BW'(idx);
    @(negedge clk);
    map_rd_en = 1'b0;
    v = map_rd_bad;
  endtask

  task automatic run_scan(input bit probe);
    logic v;
    logic held;
    req_n = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", busy, 1);
    if (probe) begin
      held = map_rd_bad;
      repeat (3000) @(negedge clk);
      read_map(0, v);
      chk(v == held, "R8 read while busy", v, held);
      start = 1'b1;  // R9
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R9 busy kept", busy, 1);
    end
    while (!done) @(negedge clk);
    chk(bad_count == CW'(exp_total()), "R6 R11 count", bad_count, exp_total());
    chk(busy == 1'b0, "R6 idle at done", busy, 0);
    chk(req_n == 2 * NB, "R3 R9 request total", req_n, 2 * NB);
    @(negedge clk);
    chk(done == 1'b0, "R6 done width", done, 0);
  endtask

  task automatic verify_map(input string tag);
    logic v;
    for (int b = 0; b < NB; b++) begin
      read_map(b, v);
      chk(v == exp_blk_bad(b), tag, v, exp_blk_bad(b));
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1; start = 1'b0; map_rd_en = 1'b0; map_rd_idx = '0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(rd_req == 1'b0, "R1 rd_req", rd_req, 0);
    chk(bad_count == '0, "R1 bad_count", bad_count, 0);
    rst = 1'b0;
    @(negedge clk);

    // scan 1: every marker erased, no gaps
    for (int b = 0; b < NB; b++) begin marks[b][0] = 8'hFF; marks[b][1] = 8'hFF; end
    gap_pct = 0;
    run_scan(1'b0);
    verify_map("R5 R7 all good");

    // scan 2: every block bad, blocked read and restart attempt mid-scan
    for (int b = 0; b < NB; b++) begin marks[b][0] = 8'h00; marks[b][1] = 8'h00; end
    run_scan(1'b1);
    verify_map("R5 R8 all bad");

    // scan 3: random markers, gapped stream, directed corners
    for (int b = 0; b < NB; b++)
      for (int p = 0; p < 2; p++)
        marks[b][p] = ($urandom % 100 < 60) ? 8'hFF : 8'($urandom % 255);
    marks[0][0] = 8'hFF; marks[0][1] = 8'hFE;          // second page only
    marks[1][0] = 8'hFF; marks[1][1] = 8'hFF;          // good, neighbours non-FF (R4)
    marks[NB-1][0] = 8'h7F; marks[NB-1][1] = 8'hFF;    // first page only
    gap_pct = 30;
    run_scan(1'b0);
    verify_map("R4 R5 R10 R11 mixed");

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 190000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule